// File: doc/BRIEF.md
# CAN Interrupt Pending and Status Encoder

This block collects interrupt requests for a CAN controller that has fifteen message buffers and one error source. Each buffer event, and each qualifying error, latches a pending bit. Software controls the block through three writable registers. An enable mask selects which pending bits drive the single interrupt line. A code-enable mask selects which pending bits the status word may report. A write-one-to-clear register lets software acknowledge individual sources.

The status word shows the pending source that should be served first, and the current bus error state. A mode input sets when an error counts as an interrupt. In one mode every error indication counts. In the other mode an error counts only when a counter increment moves the controller into a different error state. The block does not count errors itself. It takes the transmit and receive counter values and a transmit-overflow flag as inputs.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset the pending, enable and code-enable registers are all zero, `irq` is 0 and `status` is 8'h00.
- R2: A 1 on `buf_event[i]` sets pending bit i. An error set sets pending bit 15. The bit becomes visible one clock later.
- R3: A write to address 1 clears every pending bit whose `wr_data` bit is 1. Bits written as 0 keep their value. Reading address 1 returns zero.
- R4: If a set and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R5: `irq` is 1 exactly when some pending bit is 1 and its enable bit is also 1.
- R6: When no pending bit has its code-enable bit set, `status[4:0]` is 0.
- R7: A pending error with code-enable bit 15 set gives `status[4:0]` = 5'b1_0000, whatever buffers are pending.
- R8: Otherwise, for the lowest-numbered buffer i that is both pending and code-enabled, `status[4]` is 1 and `status[3:0]` is i+1.
- R9: With `err_mode` = 0, every cycle that has `err_event` high sets pending bit 15.
- R10: With `err_mode` = 1, `err_event` has no effect. Pending bit 15 is set only in a cycle with `cnt_inc` high where the error state computed from the inputs differs from the stored state.
- R11: `status[7:5]` holds the error state as sampled on the last clock edge: 0 = active when both counters are below 128, 1 = passive when either counter is 128 or more, 2 = bus-off when `bus_off` is high. Bus-off takes precedence.
- R12: A write to address 0 loads the enable register and a write to address 2 loads the code-enable register. Reads return the enable register at address 0, the code-enable register at address 2 and the pending register at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 enable, 1 clear, 2 code-enable, 3 pending (read only) |
| wr_data | input | 16 | Write data; bits 14:0 are buffers, bit 15 is the error source |
| rd_data | output | 16 | Combinational read data for `addr` |
| buf_event | input | 15 | One-cycle buffer interrupt events |
| err_event | input | 1 | Error indication |
| err_mode | input | 1 | 0: every error interrupts; 1: only error-state changes interrupt |
| cnt_inc | input | 1 | A transmit or receive error counter was incremented this cycle |
| tx_cnt | input | 8 | Transmit error counter value |
| rx_cnt | input | 8 | Receive error counter value |
| bus_off | input | 1 | Transmit counter has overflowed |
| irq | output | 1 | Interrupt request |
| status | output | 8 | {error state[2:0], flag, code[3:0]} |

## Verification
The error-state-change mode is the hardest case to reach from the ports. It sets a pending bit only when a counter increment coincides with a threshold crossing, and it must stay silent on a plain error indication or on an increment that leaves the state unchanged. The stimulus drives the counter inputs across the 128 threshold and then asserts bus-off, each time together with `cnt_inc`. Between those steps it applies an increment that crosses no threshold and a bare `err_event`. The set-versus-clear collision is produced by a clear write in the same cycle as the buffer event it would otherwise cancel.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  typedef enum logic [2:0] {
    ES_ACTIVE  = 3'd0,
    ES_PASSIVE = 3'd1,
    ES_BUSOFF  = 3'd2
  } err_state_e;

  localparam logic [1:0] ADR_ENABLE  = 2'd0;
  localparam logic [1:0] ADR_CLEAR   = 2'd1;
  localparam logic [1:0] ADR_CODE_EN = 2'd2;
  localparam logic [1:0] ADR_PENDING = 2'd3;

  // Error state from the counter top bits and the overflow flag.
  function automatic err_state_e err_state_of(input logic tx_hi,
                                              input logic rx_hi,
                                              input logic boff);
    if (boff)               return ES_BUSOFF;
    else if (tx_hi || rx_hi) return ES_PASSIVE;
    else                     return ES_ACTIVE;
  endfunction

  // Next value of one pending bit: a set overrides a clear.
  function automatic logic pend_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/can_irq_errsrc.sv
module can_irq_errsrc
  import can_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_mode,
  input  logic             err_event,
  input  logic             cnt_inc,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             bus_off,
  output logic             err_set,
  output logic [2:0]       state_q
);

  err_state_e state_now;
  err_state_e state_r;
  logic       state_moved;

  assign state_now   = err_state_of(tx_cnt[CNT_W-1], rx_cnt[CNT_W-1], bus_off);
  assign state_moved = (state_now != state_r);

  always_ff @(posedge clk) begin
    if (!rst_n) state_r <= ES_ACTIVE;
    else        state_r <= state_now;
  end

  always_comb begin
    if (err_mode) err_set = cnt_inc & state_moved;
    else          err_set = err_event;
  end

  assign state_q = state_r;

endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
  parameter  int NBUF  = 15,
  localparam int SRC_W = NBUF + 1,
  localparam int IDX_W = $clog2(NBUF + 1)
) (
  input  logic [SRC_W-1:0] req,
  output logic             flag,
  output logic [IDX_W-1:0] code
);

  // Scan downwards so the lowest buffer index is the last to be written.
  always_comb begin
    flag = 1'b0;
    code = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (req[i]) begin
        flag = 1'b1;
        code = IDX_W'(i + 1);
      end
    end
    if (req[NBUF]) begin
      flag = 1'b1;
      code = '0;
    end
  end

endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter  int NBUF  = 15,
  parameter  int CNT_W = 8,
  localparam int SRC_W = NBUF + 1,
  localparam int IDX_W = $clog2(NBUF + 1),
  localparam int ST_W  = IDX_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [SRC_W-1:0] wr_data,
  output logic [SRC_W-1:0] rd_data,
  input  logic [NBUF-1:0]  buf_event,
  input  logic             err_event,
  input  logic             err_mode,
  input  logic             cnt_inc,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             bus_off,
  output logic             irq,
  output logic [ST_W-1:0]  status
);

  logic [SRC_W-1:0] pend_q, en_q, cen_q;
  logic [SRC_W-1:0] set_vec, clr_vec;
  logic             err_set;
  logic [2:0]       state_q;
  logic             code_flag;
  logic [IDX_W-1:0] code_idx;

  can_irq_errsrc #(.CNT_W(CNT_W)) u_errsrc (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_mode  (err_mode),
    .err_event (err_event),
    .cnt_inc   (cnt_inc),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .bus_off   (bus_off),
    .err_set   (err_set),
    .state_q   (state_q)
  );

  assign set_vec = {err_set, buf_event};
  assign clr_vec = (wr_en && addr == ADR_CLEAR) ? wr_data : '0;

  for (genvar b = 0; b < SRC_W; b++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[b] <= 1'b0;
      else        pend_q[b] <= pend_next(pend_q[b], clr_vec[b], set_vec[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      cen_q <= '0;
    end else if (wr_en) begin
      if (addr == ADR_ENABLE)  en_q  <= wr_data;
      if (addr == ADR_CODE_EN) cen_q <= wr_data;
    end
  end

  can_irq_prio #(.NBUF(NBUF)) u_prio (
    .req  (pend_q & cen_q),
    .flag (code_flag),
    .code (code_idx)
  );

  assign irq    = |(pend_q & en_q);
  assign status = {state_q, code_flag, code_idx};

  always_comb begin
    case (addr)
      ADR_ENABLE:  rd_data = en_q;
      ADR_CODE_EN: rd_data = cen_q;
      ADR_PENDING: rd_data = pend_q;
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk #(
  parameter  int NBUF  = 15,
  localparam int SRC_W = NBUF + 1,
  localparam int IDX_W = $clog2(NBUF + 1),
  localparam int ST_W  = IDX_W + 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [ST_W-1:0]  status,
  input logic [SRC_W-1:0] pend_q,
  input logic [SRC_W-1:0] en_q,
  input logic [SRC_W-1:0] cen_q,
  input logic [SRC_W-1:0] set_vec,
  input logic [SRC_W-1:0] clr_vec,
  input logic             err_mode,
  input logic             cnt_inc
);

  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  p_irq_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q != '0));

  p_no_flag_no_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !status[IDX_W] |-> (status[IDX_W-1:0] == '0));

  p_error_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[NBUF] && cen_q[NBUF]) |-> (status[IDX_W:0] == {1'b1, {IDX_W{1'b0}}}));

  p_buffer_code_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[IDX_W] && !(pend_q[NBUF] && cen_q[NBUF])) |-> (status[IDX_W-1:0] != '0));

  p_mode1_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mode && !cnt_inc) |=> !$rose(pend_q[NBUF]));

endmodule

bind can_irq_ctrl can_irq_chk #(.NBUF(NBUF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .status   (status),
  .pend_q   (pend_q),
  .en_q     (en_q),
  .cen_q    (cen_q),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .err_mode (err_mode),
  .cnt_inc  (cnt_inc)
);

// File: tb/test_can_irq_ctrl.sv
module test_can_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [14:0] buf_event;
  logic        err_event, err_mode, cnt_inc, bus_off;
  logic [7:0]  tx_cnt, rx_cnt;
  logic        irq;
  logic [7:0]  status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  can_irq_ctrl i_can_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .buf_event(buf_event), .err_event(err_event),
    .err_mode(err_mode), .cnt_inc(cnt_inc), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .bus_off(bus_off), .irq(irq), .status(status)
  );

  // {addr, wr, data, buf_ev, err_ev, exp_pend, exp_irq, exp_status}
  localparam int NV = 9;
  localparam logic [59:0] TBL [NV] = '{
    {2'd0, 1'b1, 16'h8005, 15'h0000, 1'b0, 16'h0000, 1'b0, 8'h00},
    {2'd2, 1'b1, 16'hFFFF, 15'h0000, 1'b0, 16'h0000, 1'b0, 8'h00},
    {2'd0, 1'b0, 16'h0000, 15'h0008, 1'b0, 16'h0008, 1'b0, 8'h14},
    {2'd0, 1'b0, 16'h0000, 15'h0201, 1'b0, 16'h0209, 1'b1, 8'h11},
    {2'd0, 1'b0, 16'h0000, 15'h0000, 1'b1, 16'h8209, 1'b1, 8'h10},
    {2'd1, 1'b1, 16'h8001, 15'h0001, 1'b0, 16'h0209, 1'b1, 8'h11},
    {2'd1, 1'b1, 16'h0001, 15'h0000, 1'b0, 16'h0208, 1'b0, 8'h14},
    {2'd2, 1'b1, 16'h0200, 15'h0000, 1'b0, 16'h0208, 1'b0, 8'h1A},
    {2'd1, 1'b1, 16'hFFFF, 15'h0000, 1'b0, 16'h0000, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; addr = 2'd0; wr_data = '0; buf_event = '0;
    err_event = 0; cnt_inc = 0;
  endtask

  // Inputs are set just after a rising edge; one edge later results are sampled.
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wr_data = d; tick(); idle();
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    addr = a; #1; v = rd_data;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; err_mode = 0; tx_cnt = 0; rx_cnt = 0; bus_off = 0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    // R1: reset state
    chk("R1 irq", irq, 0);
    chk("R1 status", status, 8'h00);
    peek(2'd3, v); chk("R1 pending", v, 0);
    peek(2'd0, v); chk("R1 enable", v, 0);
    peek(2'd2, v); chk("R1 code enable", v, 0);
    idle();

    // Table: R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int k = 0; k < NV; k++) begin
      addr = TBL[k][59:58]; wr_en = TBL[k][57]; wr_data = TBL[k][56:41];
      buf_event = TBL[k][40:26]; err_event = TBL[k][25];
      tick();
      idle();
      chk($sformatf("R5 irq step %0d", k), irq, TBL[k][8]);
      chk($sformatf("R6/R7/R8 status step %0d", k), status, TBL[k][7:0]);
      peek(2'd3, v);
      chk($sformatf("R2/R3/R4 pending step %0d", k), v, TBL[k][24:9]);
      addr = 2'd0;
    end

    // R12: register readback
    peek(2'd0, v); chk("R12 enable readback", v, 16'h8005);
    peek(2'd2, v); chk("R12 code enable readback", v, 16'h0200);
    peek(2'd1, v); chk("R3 clear reads zero", v, 16'h0000);
    idle();

    // R9: every error in mode 0
    wr(2'd2, 16'hFFFF);
    err_event = 1; tick(); idle();
    chk("R9 first error status", status, 8'h10);
    chk("R9 first error irq", irq, 1);
    wr(2'd1, 16'h8000);
    chk("R3 error cleared", status, 8'h00);
    err_event = 1; tick(); idle();
    chk("R9 second error sets again", status, 8'h10);
    wr(2'd1, 16'h8000);

    // R11: passive via receive counter, no interrupt without error
    rx_cnt = 8'd200; tick();
    chk("R11 passive from rx", status, 8'h20);
    rx_cnt = 8'd0; tick();
    chk("R11 back to active", status, 8'h00);

    // R10: state-change mode
    err_mode = 1;
    err_event = 1; tick(); idle();
    peek(2'd3, v); chk("R10 plain error ignored", v, 16'h0000);
    idle();
    tx_cnt = 8'd130; cnt_inc = 1; tick(); idle();
    chk("R10 R11 active to passive", status, 8'h30);
    wr(2'd1, 16'h8000);
    chk("R11 passive after clear", status, 8'h20);
    tx_cnt = 8'd131; cnt_inc = 1; tick(); idle();
    peek(2'd3, v); chk("R10 no state change no set", v, 16'h0000);
    idle();
    bus_off = 1; cnt_inc = 1; tick(); idle();
    chk("R10 R11 bus-off", status, 8'h50);
    chk("R5 irq on error", irq, 1);

    // R1: reset in mid-run
    bus_off = 0; tx_cnt = 0; err_mode = 0;
    rst_n = 0; tick(); rst_n = 1;
    chk("R1 reset clears status", status, 8'h00);
    chk("R1 reset clears irq", irq, 0);
    peek(2'd3, v); chk("R1 reset clears pending", v, 0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule